// File: doc/BRIEF.md
# SDRAM Mode Register Command Issuer

This block keeps a software-visible copy of the SDRAM mode word. It turns every store into that word into a single load-mode command on the memory command pins. Software stores the word over a small register bus. Once the controller's command arbiter reports that the bus is free and every bank is precharged, the block drives one command cycle. In that cycle the stored word sits on the row address pins, so the device can capture it. The word carries burst length, CAS latency and write-burst mode, or low-power settings when it goes to the extended register.

One write path serves both device registers. An external select input, sampled together with the write, decides the target. With the select low, the command addresses the standard mode register. With it high, the command addresses the extended mode register. Reads return the stored contents and never disturb the memory pins. After each command the block stays busy for a programmable settle time. A write that lands while the block is busy updates the word at once, but it produces only one further command, and only after the current one has finished.

Top module: `sdram_mrs_issuer`

## Requirements
- R1: A register write at address 0 stores the ROW_W-bit data as the mode word. A read at address 0 returns it on reg_rdata in the cycle after the read. Writes to addresses other than 0 and 1 change nothing, and reads of them return 0.
- R2: Each write at address 0 raises busy in the following cycle and results in exactly one load-mode command.
- R3: In a command cycle, sd_cs_n, sd_ras_n, sd_cas_n and sd_we_n are all 0 and sd_addr carries the mode word. In every other cycle all four are 1 and sd_addr and sd_ba are 0.
- R4: sd_ba is 00 (standard register) when ext_sel was 0 at the write, and 01 (extended register) when ext_sel was 1.
- R5: A pending write waits, with cmd_req and busy high, until arb_idle is 1 on a clock edge while the block is idle. The command cycle follows that edge.
- R6: After the command cycle, busy stays high for D cycles with no command, where D is the delay register value raised to at least MRD_MIN (2). busy then falls unless a write is pending.
- R7: Writes at address 0 that arrive while a command is pending or in progress, including one on the very edge a command is issued, give exactly one further command after the settle time. That command carries the latest word and select.
- R8: Reads, and writes to unused addresses, never produce a command and never change busy.
- R9: Address 1 is the delay register. It is ROW_W bits wide, resets to 2 and reads back what was written.
- R10: While rst_n is low, busy and cmd_req are 0, the command pins are all 1, the mode word is 0 and the delay register is 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert, synchronously released |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | ADDR_W | Register address (0 mode word, 1 delay) |
| reg_wdata | input | ROW_W | Write data |
| reg_rdata | output | ROW_W | Read data, valid the cycle after reg_rd |
| ext_sel | input | 1 | Sends the write to the extended register when high |
| arb_idle | input | 1 | Arbiter grant: bus free, all banks precharged |
| cmd_req | output | 1 | Command waiting for grant |
| busy | output | 1 | Command pending, in progress or settling |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_ba | output | BA_W | Bank address, selects the target register |
| sd_addr | output | ROW_W | Row address, carries the mode word |

## Verification
The hardest case to reach from the ports is a new store of the mode word on the exact clock edge that launches the command for the previous store. If the pending flag were cleared instead of re-armed on that edge, the later word would be lost. The stimulus keeps the grant high and issues stores on back-to-back cycles, so the second store meets the issue edge and the third overwrites it while the block settles. A separate sequence withholds the grant for many cycles, then releases it. The delay register is swept through 0, 1 and 7 so that both the floor of 2 and a long settle time are covered.

// File: rtl/sdram_mrs_pkg.sv
package sdram_mrs_pkg;

  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_CMD  = 2'd1,
    SEQ_HOLD = 2'd2
  } seq_state_e;

  typedef struct packed {
    logic cs_n;
    logic ras_n;
    logic cas_n;
    logic we_n;
  } sd_cmd_t;

  localparam sd_cmd_t CMD_DESELECT  = '{cs_n: 1'b1, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};
  localparam sd_cmd_t CMD_LOAD_MODE = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b0};

  localparam int BANK_STD_CODE = 0;
  localparam int BANK_EXT_CODE = 1;

  localparam int REG_MODE_IDX  = 0;
  localparam int REG_DELAY_IDX = 1;

  localparam int DELAY_RESET   = 2;

endpackage

// File: rtl/sdram_mrs_regs.sv
module sdram_mrs_regs
  import sdram_mrs_pkg::*;
#(
  parameter int ADDR_W = 2,
  parameter int ROW_W  = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [ROW_W-1:0]  reg_wdata,
  input  logic              ext_sel,
  input  logic              take,
  output logic [ROW_W-1:0]  mode_q,
  output logic [ROW_W-1:0]  delay_q,
  output logic              pend_q,
  output logic              pend_ext_q,
  output logic [ROW_W-1:0]  rdata_q
);

  logic             hit_mode;
  logic             hit_delay;
  logic [ROW_W-1:0] mode_d;
  logic [ROW_W-1:0] delay_d;
  logic             pend_d;
  logic             pend_ext_d;
  logic [ROW_W-1:0] rdata_d;

  assign hit_mode  = (reg_addr == ADDR_W'(REG_MODE_IDX));
  assign hit_delay = (reg_addr == ADDR_W'(REG_DELAY_IDX));

  // next-state
  always_comb begin
    mode_d     = mode_q;
    delay_d    = delay_q;
    pend_d     = pend_q;
    pend_ext_d = pend_ext_q;
    if (take) begin
      pend_d = 1'b0;
    end
    // a store on the issue edge re-arms the request
    if (reg_wr && hit_mode) begin
      mode_d     = reg_wdata;
      pend_d     = 1'b1;
      pend_ext_d = ext_sel;
    end
    if (reg_wr && hit_delay) begin
      delay_d = reg_wdata;
    end
  end

  always_comb begin
    if (hit_mode) begin
      rdata_d = mode_q;
    end else if (hit_delay) begin
      rdata_d = delay_q;
    end else begin
      rdata_d = '0;
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q     <= '0;
      delay_q    <= ROW_W'(DELAY_RESET);
      pend_q     <= 1'b0;
      pend_ext_q <= 1'b0;
    end else begin
      mode_q     <= mode_d;
      delay_q    <= delay_d;
      pend_q     <= pend_d;
      pend_ext_q <= pend_ext_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= '0;
    end else if (reg_rd) begin
      rdata_q <= rdata_d;
    end
  end

endmodule

// File: rtl/sdram_mrs_seq.sv
module sdram_mrs_seq
  import sdram_mrs_pkg::*;
#(
  parameter int ROW_W   = 13,
  parameter int MRD_MIN = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pend,
  input  logic             arb_idle,
  input  logic [ROW_W-1:0] delay_val,
  output logic             fire,
  output logic             seq_idle
);

  localparam logic [ROW_W-1:0] FLOOR = ROW_W'(MRD_MIN);

  seq_state_e       state_q, state_d;
  logic [ROW_W-1:0] cnt_q, cnt_d;
  logic [ROW_W-1:0] eff_delay;

  assign eff_delay = (delay_val < FLOOR) ? FLOOR : delay_val;
  assign seq_idle  = (state_q == SEQ_IDLE);
  assign fire      = seq_idle && pend && arb_idle;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    unique case (state_q)
      SEQ_IDLE: begin
        if (fire) begin
          state_d = SEQ_CMD;
        end
      end
      SEQ_CMD: begin
        state_d = SEQ_HOLD;
        cnt_d   = eff_delay;
      end
      SEQ_HOLD: begin
        if (cnt_q == ROW_W'(1)) begin
          state_d = SEQ_IDLE;
        end else begin
          cnt_d = cnt_q - ROW_W'(1);
        end
      end
      default: begin
        state_d = SEQ_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SEQ_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

endmodule

// File: rtl/sdram_mrs_pins.sv
module sdram_mrs_pins
  import sdram_mrs_pkg::*;
#(
  parameter int ROW_W = 13,
  parameter int BA_W  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fire,
  input  logic             use_ext,
  input  logic [ROW_W-1:0] word,
  output logic             sd_cs_n,
  output logic             sd_ras_n,
  output logic             sd_cas_n,
  output logic             sd_we_n,
  output logic [BA_W-1:0]  sd_ba,
  output logic [ROW_W-1:0] sd_addr
);

  sd_cmd_t          cmd_q, cmd_d;
  logic [BA_W-1:0]  ba_q, ba_d;
  logic [ROW_W-1:0] addr_q, addr_d;

  always_comb begin
    if (fire) begin
      cmd_d  = CMD_LOAD_MODE;
      ba_d   = use_ext ? BA_W'(BANK_EXT_CODE) : BA_W'(BANK_STD_CODE);
      addr_d = word;
    end else begin
      cmd_d  = CMD_DESELECT;
      ba_d   = '0;
      addr_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q  <= CMD_DESELECT;
      ba_q   <= '0;
      addr_q <= '0;
    end else begin
      cmd_q  <= cmd_d;
      ba_q   <= ba_d;
      addr_q <= addr_d;
    end
  end

  assign sd_cs_n  = cmd_q.cs_n;
  assign sd_ras_n = cmd_q.ras_n;
  assign sd_cas_n = cmd_q.cas_n;
  assign sd_we_n  = cmd_q.we_n;
  assign sd_ba    = ba_q;
  assign sd_addr  = addr_q;

endmodule

// File: rtl/sdram_mrs_issuer.sv
module sdram_mrs_issuer #(
  parameter int ADDR_W  = 2,
  parameter int ROW_W   = 13,
  parameter int BA_W    = 2,
  parameter int MRD_MIN = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [ROW_W-1:0]  reg_wdata,
  output logic [ROW_W-1:0]  reg_rdata,
  input  logic              ext_sel,
  input  logic              arb_idle,
  output logic              cmd_req,
  output logic              busy,
  output logic              sd_cs_n,
  output logic              sd_ras_n,
  output logic              sd_cas_n,
  output logic              sd_we_n,
  output logic [BA_W-1:0]   sd_ba,
  output logic [ROW_W-1:0]  sd_addr
);

  logic [ROW_W-1:0] mode_q;
  logic [ROW_W-1:0] delay_q;
  logic             pend_q;
  logic             pend_ext_q;
  logic             fire;
  logic             seq_idle;

  sdram_mrs_regs #(.ADDR_W(ADDR_W), .ROW_W(ROW_W)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_wr     (reg_wr),
    .reg_rd     (reg_rd),
    .reg_addr   (reg_addr),
    .reg_wdata  (reg_wdata),
    .ext_sel    (ext_sel),
    .take       (fire),
    .mode_q     (mode_q),
    .delay_q    (delay_q),
    .pend_q     (pend_q),
    .pend_ext_q (pend_ext_q),
    .rdata_q    (reg_rdata)
  );

  sdram_mrs_seq #(.ROW_W(ROW_W), .MRD_MIN(MRD_MIN)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .pend      (pend_q),
    .arb_idle  (arb_idle),
    .delay_val (delay_q),
    .fire      (fire),
    .seq_idle  (seq_idle)
  );

  sdram_mrs_pins #(.ROW_W(ROW_W), .BA_W(BA_W)) u_pins (
    .clk      (clk),
    .rst_n    (rst_n),
    .fire     (fire),
    .use_ext  (pend_ext_q),
    .word     (mode_q),
    .sd_cs_n  (sd_cs_n),
    .sd_ras_n (sd_ras_n),
    .sd_cas_n (sd_cas_n),
    .sd_we_n  (sd_we_n),
    .sd_ba    (sd_ba),
    .sd_addr  (sd_addr)
  );

  assign busy    = pend_q | ~seq_idle;
  assign cmd_req = pend_q & seq_idle;

endmodule

// File: rtl/sdram_mrs_issuer_chk.sv
module sdram_mrs_issuer_chk #(
  parameter int ADDR_W  = 2,
  parameter int ROW_W   = 13,
  parameter int BA_W    = 2,
  parameter int MRD_MIN = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_wr,
  input logic [ADDR_W-1:0] reg_addr,
  input logic              arb_idle,
  input logic              busy,
  input logic              sd_cs_n,
  input logic              sd_ras_n,
  input logic              sd_cas_n,
  input logic              sd_we_n,
  input logic [BA_W-1:0]   sd_ba,
  input logic [ROW_W-1:0]  sd_addr
);

  logic [7:0] gap_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap_q <= 8'hFF;
    end else if (!sd_cs_n) begin
      gap_q <= 8'd0;
    end else if (gap_q != 8'hFF) begin
      gap_q <= gap_q + 8'd1;
    end
  end

  assert_cmd_all_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !sd_cs_n |-> (!sd_ras_n && !sd_cas_n && !sd_we_n));

  assert_idle_pins_R3: assert property (@(posedge clk) disable iff (!rst_n)
    sd_cs_n |-> (sd_ras_n && sd_cas_n && sd_we_n && sd_addr == '0 && sd_ba == '0));

  assert_bank_code_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !sd_cs_n |-> (sd_ba == BA_W'(0) || sd_ba == BA_W'(1)));

  assert_write_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == ADDR_W'(0)) |=> busy);

  assert_grant_first_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !sd_cs_n |-> $past(arb_idle));

  assert_settle_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !sd_cs_n |=> (busy && sd_cs_n));

  assert_min_gap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !sd_cs_n |-> (gap_q >= 8'(MRD_MIN + 1)));

  assert_quiet_stays_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !(reg_wr && reg_addr == ADDR_W'(0))) |=> (!busy && sd_cs_n));

endmodule

bind sdram_mrs_issuer sdram_mrs_issuer_chk #(
  .ADDR_W(ADDR_W), .ROW_W(ROW_W), .BA_W(BA_W), .MRD_MIN(MRD_MIN)
) u_chk (.*);

// File: tb/sdram_mrs_issuer_bench.sv
`timescale 1ns/1ps
module sdram_mrs_issuer_bench;

  localparam int ADDR_W = 2;
  localparam int ROW_W  = 13;
  localparam int BA_W   = 2;

  logic              clk;
  logic              rst_n;
  logic              reg_wr;
  logic              reg_rd;
  logic [ADDR_W-1:0] reg_addr;
  logic [ROW_W-1:0]  reg_wdata;
  logic [ROW_W-1:0]  reg_rdata;
  logic              ext_sel;
  logic              arb_idle;
  logic              cmd_req;
  logic              busy;
  logic              sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n;
  logic [BA_W-1:0]   sd_ba;
  logic [ROW_W-1:0]  sd_addr;

  sdram_mrs_issuer #(.ADDR_W(ADDR_W), .ROW_W(ROW_W), .BA_W(BA_W), .MRD_MIN(2)) u_sdram_mrs_issuer (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ext_sel(ext_sel), .arb_idle(arb_idle),
    .cmd_req(cmd_req), .busy(busy), .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n),
    .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n), .sd_ba(sd_ba), .sd_addr(sd_addr)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  int total = 0;
  int bad   = 0;
  int ncmd  = 0;
  int last_addr = -1;
  int last_ba   = -1;
  bit done = 1'b0;

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // behavioural reference model
  int m_mode, m_dly, m_pend, m_pext, m_phase, m_cnt, m_rdata;
  int m_cmd, m_ba, m_caddr, m_fire;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_mode = 0; m_dly = 2; m_pend = 0; m_pext = 0; m_phase = 0; m_cnt = 0;
      m_rdata = 0; m_cmd = 0; m_ba = 0; m_caddr = 0;
    end else begin
      m_fire = (m_phase == 0 && m_pend != 0 && arb_idle) ? 1 : 0;
      m_cmd = m_fire;
      m_ba = m_fire ? m_pext : 0;
      m_caddr = m_fire ? m_mode : 0;
      if (m_phase == 1) begin
        m_phase = 2;
        m_cnt = (m_dly < 2) ? 2 : m_dly;
      end else if (m_phase == 2) begin
        if (m_cnt == 1) m_phase = 0; else m_cnt--;
      end else if (m_fire != 0) begin
        m_phase = 1;
      end
      if (reg_rd) m_rdata = (reg_addr == 0) ? m_mode : (reg_addr == 1) ? m_dly : 0;
      if (m_fire != 0) m_pend = 0;
      if (reg_wr && reg_addr == 0) begin m_mode = int'(reg_wdata); m_pend = 1; m_pext = int'(ext_sel); end
      if (reg_wr && reg_addr == 1) m_dly = int'(reg_wdata);
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R3", "cs_n", 32'(sd_cs_n), 32'(m_cmd == 0));
      chk("R3", "ras/cas/we", 32'({sd_ras_n, sd_cas_n, sd_we_n}), (m_cmd != 0) ? 32'd0 : 32'd7);
      chk("R3", "addr", 32'(sd_addr), 32'(m_caddr));
      chk("R4", "ba", 32'(sd_ba), 32'(m_ba));
      chk("R6", "busy", 32'(busy), 32'(m_pend != 0 || m_phase != 0));
      chk("R5", "cmd_req", 32'(cmd_req), 32'(m_pend != 0 && m_phase == 0));
      chk("R1", "rdata", 32'(reg_rdata), 32'(m_rdata));
      if (!sd_cs_n) begin
        ncmd++;
        last_addr = int'(sd_addr);
        last_ba = int'(sd_ba);
      end
    end
  end

  task automatic cyc(int n);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic wr(int a, int d, bit e);
    reg_wr = 1'b1; reg_addr = ADDR_W'(a); reg_wdata = ROW_W'(d); ext_sel = e;
    @(posedge clk); #1;
    reg_wr = 1'b0; ext_sel = 1'b0;
  endtask

  task automatic rd(int a, output int v);
    reg_rd = 1'b1; reg_addr = ADDR_W'(a);
    @(posedge clk); #1;
    reg_rd = 1'b0;
    v = int'(reg_rdata);
  endtask

  task automatic busy_len(int d, string req);
    int n;
    n = 0;
    wr(0, 13'h055, 1'b0);
    for (int i = 0; i < 24; i++) begin
      @(negedge clk);
      if (busy) n++;
    end
    @(posedge clk); #1;
    chk(req, "busy length", 32'(n), 32'(2 + d));
  endtask

  initial begin
    int v, n0;
    rst_n = 1'b0; reg_wr = 1'b0; reg_rd = 1'b0; reg_addr = '0; reg_wdata = '0;
    ext_sel = 1'b0; arb_idle = 1'b0;
    cyc(3);
    @(negedge clk);
    chk("R10", "reset busy", 32'(busy), 32'd0);
    chk("R10", "reset cmd_req", 32'(cmd_req), 32'd0);
    chk("R10", "reset pins", 32'({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n}), 32'hF);
    @(posedge clk); #1;
    rst_n = 1'b1;
    cyc(2);
    rd(0, v); chk("R10", "reset mode word", 32'(v), 32'd0);
    rd(1, v); chk("R9", "reset delay", 32'(v), 32'd2);

    // standard register write with grant
    arb_idle = 1'b1;
    n0 = ncmd;
    wr(0, 13'h032, 1'b0);
    cyc(12);
    chk("R2", "one command", 32'(ncmd), 32'(n0 + 1));
    chk("R3", "word on address", 32'(last_addr), 32'h032);
    chk("R4", "standard bank", 32'(last_ba), 32'd0);
    rd(0, v); chk("R1", "readback", 32'(v), 32'h032);

    // extended register
    n0 = ncmd;
    wr(0, 13'h1040, 1'b1);
    cyc(12);
    chk("R4", "extended count", 32'(ncmd), 32'(n0 + 1));
    chk("R4", "extended bank", 32'(last_ba), 32'd1);
    chk("R3", "extended word", 32'(last_addr), 32'h1040);

    // grant withheld
    arb_idle = 1'b0;
    n0 = ncmd;
    wr(0, 13'h021, 1'b0);
    cyc(10);
    chk("R5", "no command without grant", 32'(ncmd), 32'(n0));
    chk("R5", "cmd_req while waiting", 32'(cmd_req), 32'd1);
    chk("R5", "busy while waiting", 32'(busy), 32'd1);
    arb_idle = 1'b1;
    cyc(10);
    chk("R5", "command after grant", 32'(ncmd), 32'(n0 + 1));
    chk("R5", "granted word", 32'(last_addr), 32'h021);

    // delay register and settle time
    wr(1, 7, 1'b0);
    rd(1, v); chk("R9", "delay readback", 32'(v), 32'd7);
    busy_len(7, "R6");
    wr(1, 0, 1'b0);
    busy_len(2, "R6");
    wr(1, 1, 1'b0);
    busy_len(2, "R6");
    wr(1, 3, 1'b0);

    // back-to-back stores, second on the issue edge
    n0 = ncmd;
    wr(0, 13'h101, 1'b0);
    wr(0, 13'h102, 1'b0);
    wr(0, 13'h103, 1'b1);
    cyc(20);
    chk("R7", "two commands", 32'(ncmd), 32'(n0 + 2));
    chk("R7", "latest word", 32'(last_addr), 32'h103);
    chk("R7", "latest select", 32'(last_ba), 32'd1);

    // reads and unused addresses
    n0 = ncmd;
    for (int i = 0; i < 4; i++) rd(i, v);
    wr(2, 13'h1FFF, 1'b0);
    wr(3, 13'h0AA, 1'b1);
    cyc(3);
    chk("R8", "no command from reads", 32'(ncmd), 32'(n0));
    chk("R8", "busy unchanged", 32'(busy), 32'd0);
    rd(0, v); chk("R1", "word kept", 32'(v), 32'h103);
    rd(1, v); chk("R1", "delay kept", 32'(v), 32'd3);
    rd(2, v); chk("R1", "unused reads zero", 32'(v), 32'd0);

    cyc(4);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(4 * 20000);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule